// File: doc/BRIEF.md
# Serial Port FIFO and Status Front End

This block sits between a simple word-addressed register bus and a serial shift engine. It contains a transmit FIFO and a receive FIFO. Each holds 32 entries of up to 32 bits. Software writes transmit words and reads received words through a single data register. The shift engine takes words from the transmit FIFO head and delivers received words into the receive FIFO.

Three control and status registers sit beside the data register. A configuration register holds the two FIFO thresholds and the two DMA request enables. An interrupt enable register selects which conditions drive the shared interrupt line. A status register reports the FIFO levels, the busy state and three sticky error flags that are cleared by writing ones.

The threshold fields and the level fields are offset by one. A threshold field value N means N+1 entries. The receive level field reports the entry count minus one. The transmit field reports open slots modulo 32, so that zero stands for all 32 slots open. The receive timeout counter lives outside this block and supplies only an event input.

Top module: `xfer_fifo_hub`

## Requirements
- R1: After reset the configuration and interrupt enable registers read 0, the status register reads 0x40, and `irq`, `txDmaReq` and `rxDmaReq` are low.
- R2: Register index 0 is the configuration register, read back in bits 11:0. It holds the TX threshold in bits 4:0, the RX threshold in bits 9:5, the TX DMA enable in bit 10 and the RX DMA enable in bit 11. Index 1 is the interrupt enable register, read back in bits 6:1. All other bits of both registers read 0.
- R3: A bus write to index 3 appends a word to the TX FIFO, and a write while the FIFO is full is dropped. `txWord` shows the oldest word. `engTxPop` removes it, so words leave in the order they were written.
- R4: `engRxPush` appends `rxWord` to the RX FIFO. A bus read of index 3 returns the oldest word and removes it. A read while the FIFO is empty changes no state.
- R5: Status bit 6 is set while the TX FIFO is not full. Status bits 11:7 hold the number of free TX slots modulo 32.
- R6: Status bit 14 is set while the RX FIFO holds data. Status bits 19:15 hold the RX count minus one, or 0 when the FIFO is empty.
- R7: A push into a full RX FIFO drops the word and sets the sticky overrun flag, status bit 20.
- R8: An `engTxPop` on an empty TX FIFO sets the sticky underrun flag, status bit 12.
- R9: A pulse on `engBitErr` sets the sticky bit-count error flag, status bit 21.
- R10: Writing the status register clears each error flag whose bit is written as 1 and leaves the others alone. A set event in the same cycle wins over the clear.
- R11: Status bit 0 follows `engBusy`.
- R12: `irq` is the OR of six enabled conditions. Enable bit 1 gates `rxTimeoutEvt`. Bit 2 gates RX count at or above the RX threshold plus one. Bit 3 gates free TX slots at or above the TX threshold plus one. Bits 4, 5 and 6 gate the overrun, underrun and bit-count flags.
- R13: `txDmaReq` is high when its enable is set and free TX slots are at least the TX threshold plus one. `rxDmaReq` is high when its enable is set and the RX count is at least the RX threshold plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| engBusy | input | 1 | Shift engine busy |
| engTxPop | input | 1 | Engine takes the TX head word |
| txWord | output | DATA_W | TX FIFO head word |
| engRxPush | input | 1 | Engine delivers a received word |
| rxWord | input | DATA_W | Received word |
| engBitErr | input | 1 | Bit-count error event |
| rxTimeoutEvt | input | 1 | Receive inactivity timeout event |
| irq | output | 1 | Shared interrupt |
| txDmaReq | output | 1 | TX DMA service request |
| rxDmaReq | output | 1 | RX DMA service request |

## Verification
Register writes, FIFO pushes and pops, and error events take effect at the clock edge on which they are presented. They are visible on `busRdata`, `irq` and the DMA requests in the cycle after that edge, with no further latency. The busy bit and the timeout term of `irq` are combinational and follow their inputs within the same cycle. The bench therefore drives every stimulus on a falling edge and removes it on the next falling edge. It reads results only after that second falling edge, or a moment after it sets a combinational input.

// File: rtl/xfh_pkg.sv
package xfh_pkg;
  localparam int BUS_W   = 32;
  localparam int FIELD_W = 5;
  localparam int CFG_W   = 12;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_IEN  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CFG_RXTHR_LO = 5;
  localparam int CFG_TXDMA    = 10;
  localparam int CFG_RXDMA    = 11;

  localparam int IEN_TMO = 1;
  localparam int IEN_RXT = 2;
  localparam int IEN_TXT = 3;
  localparam int IEN_ROR = 4;
  localparam int IEN_TUR = 5;
  localparam int IEN_BCE = 6;

  localparam int STAT_BUSY     = 0;
  localparam int STAT_TNF      = 6;
  localparam int STAT_TXLVL_LO = 7;
  localparam int STAT_TUR      = 12;
  localparam int STAT_RNE      = 14;
  localparam int STAT_RXLVL_LO = 15;
  localparam int STAT_ROR      = 20;
  localparam int STAT_BCE      = 21;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobes_t;
endpackage

// File: rtl/xfh_fifo.sv
module xfh_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= stepPtr(wrPtr);
      if (pop)  rdPtr <= stepPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = store[rdPtr];
endmodule

// File: rtl/xfh_datapath.sv
module xfh_datapath
  import xfh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] txIn,
  input  logic [DATA_W-1:0] rxIn,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  xfh_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pop(strobes.txPop),
    .wdata(txIn), .rdata(txHead), .count(txCount)
  );

  xfh_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.rxPush), .pop(strobes.rxPop),
    .wdata(rxIn), .rdata(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/xfh_control.sv
module xfh_control
  import xfh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              engBusy,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              engBitErr,
  input  logic              rxTimeoutEvt,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  output fifoStrobes_t      strobes,
  output logic [CFG_W-1:0]  cfgReg,
  output logic [6:1]        ienReg,
  output logic [BUS_W-1:0]  statusWord,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  logic wrCfg, wrIen, wrStat, wrData, rdData;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic flagTur, flagRor, flagBce;
  logic txAtThr, rxAtThr;
  logic [CNT_W-1:0] txFree, rxMinus;
  logic [FIELD_W-1:0] txThr, rxThr;

  assign wrCfg  = busSel &  busWrite & (busAddr == REG_CFG);
  assign wrIen  = busSel &  busWrite & (busAddr == REG_IEN);
  assign wrStat = busSel &  busWrite & (busAddr == REG_STAT);
  assign wrData = busSel &  busWrite & (busAddr == REG_DATA);
  assign rdData = busSel & ~busWrite & (busAddr == REG_DATA);

  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  assign strobes.txPush = wrData & ~txFull;
  assign strobes.txPop  = engTxPop & ~txEmpty;
  assign strobes.rxPush = engRxPush & ~rxFull;
  assign strobes.rxPop  = rdData & ~rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      ienReg  <= '0;
      flagTur <= 1'b0;
      flagRor <= 1'b0;
      flagBce <= 1'b0;
    end else begin
      if (wrCfg) cfgReg <= busWdata[CFG_W-1:0];
      if (wrIen) ienReg <= busWdata[6:1];
      if (wrStat) begin
        flagTur <= flagTur & ~busWdata[STAT_TUR];
        flagRor <= flagRor & ~busWdata[STAT_ROR];
        flagBce <= flagBce & ~busWdata[STAT_BCE];
      end
      if (engTxPop & txEmpty) flagTur <= 1'b1;
      if (engRxPush & rxFull) flagRor <= 1'b1;
      if (engBitErr)          flagBce <= 1'b1;
    end
  end

  assign txThr   = cfgReg[FIELD_W-1:0];
  assign rxThr   = cfgReg[CFG_RXTHR_LO +: FIELD_W];
  assign txFree  = CNT_W'(DEPTH) - txCount;
  assign rxMinus = rxCount - CNT_W'(1);
  assign txAtThr = int'(txFree) >= int'(txThr) + 1;
  assign rxAtThr = int'(rxCount) >= int'(rxThr) + 1;

  always_comb begin
    statusWord = '0;
    statusWord[STAT_BUSY] = engBusy;
    statusWord[STAT_TNF]  = ~txFull;
    statusWord[STAT_TXLVL_LO +: FIELD_W] = FIELD_W'(txFree);
    statusWord[STAT_TUR]  = flagTur;
    statusWord[STAT_RNE]  = ~rxEmpty;
    statusWord[STAT_RXLVL_LO +: FIELD_W] = rxEmpty ? '0 : FIELD_W'(rxMinus);
    statusWord[STAT_ROR]  = flagRor;
    statusWord[STAT_BCE]  = flagBce;
  end

  always_comb begin
    case (busAddr)
      REG_CFG:  busRdata = BUS_W'(cfgReg);
      REG_IEN:  busRdata = BUS_W'({ienReg, 1'b0});
      REG_STAT: busRdata = statusWord;
      default:  busRdata = BUS_W'(rxHead);
    endcase
  end

  assign irq = (ienReg[IEN_TMO] & rxTimeoutEvt) |
               (ienReg[IEN_RXT] & rxAtThr) |
               (ienReg[IEN_TXT] & txAtThr) |
               (ienReg[IEN_ROR] & flagRor) |
               (ienReg[IEN_TUR] & flagTur) |
               (ienReg[IEN_BCE] & flagBce);

  assign txDmaReq = cfgReg[CFG_TXDMA] & txAtThr;
  assign rxDmaReq = cfgReg[CFG_RXDMA] & rxAtThr;
endmodule

// File: rtl/xfer_fifo_hub.sv
module xfer_fifo_hub
  import xfh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              engBusy,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] txWord,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              engBitErr,
  input  logic              rxTimeoutEvt,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  fifoStrobes_t      strobes;
  logic [DATA_W-1:0] rxHead;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [CFG_W-1:0]  cfgReg;
  logic [6:1]        ienReg;
  logic [BUS_W-1:0]  statusWord;

  xfh_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txIn(busWdata[DATA_W-1:0]), .rxIn(rxWord),
    .txHead(txWord), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );

  xfh_control #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .engBusy(engBusy), .engTxPop(engTxPop), .engRxPush(engRxPush),
    .engBitErr(engBitErr), .rxTimeoutEvt(rxTimeoutEvt),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .strobes(strobes), .cfgReg(cfgReg), .ienReg(ienReg),
    .statusWord(statusWord), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );
endmodule

// File: rtl/xfh_checker.sv
module xfh_checker
  import xfh_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWrite,
  input logic [1:0]       busAddr,
  input logic [31:0]      busWdata,
  input logic             engTxPop,
  input logic             engRxPush,
  input logic             engBitErr,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [CFG_W-1:0] cfgReg,
  input logic [6:1]       ienReg,
  input logic [31:0]      statusWord,
  input logic             irq,
  input logic             txDmaReq,
  input logic             rxDmaReq
);
  logic statWr;
  assign statWr = busSel & busWrite & (busAddr == REG_STAT);

  assert_rx_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxCount) <= DEPTH);

  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    int'(txCount) <= DEPTH);

  assert_rx_empty_field_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[STAT_RNE] |-> (statusWord[STAT_RXLVL_LO +: FIELD_W] == '0));

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && int'(rxCount) == DEPTH) |=> statusWord[STAT_ROR] && $stable(rxCount));

  assert_underrun_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && txCount == '0) |=> statusWord[STAT_TUR]);

  assert_bce_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    engBitErr |=> statusWord[STAT_BCE]);

  assert_ror_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[STAT_ROR] && !(statWr && busWdata[STAT_ROR])) |=> statusWord[STAT_ROR]);

  assert_masked_irq_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == '0) |-> !irq);

  assert_dma_enable_R13: assert property (@(posedge clk) disable iff (!rstN)
    (txDmaReq |-> cfgReg[CFG_TXDMA]) and (rxDmaReq |-> cfgReg[CFG_RXDMA]));
endmodule

bind xfer_fifo_hub xfh_checker #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .engTxPop(engTxPop),
  .engRxPush(engRxPush), .engBitErr(engBitErr), .txCount(txCount),
  .rxCount(rxCount), .cfgReg(cfgReg), .ienReg(ienReg),
  .statusWord(statusWord), .irq(irq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
);

// File: tb/tb_xfer_fifo_hub.sv
`timescale 1ns/1ps
module tb_xfer_fifo_hub;
  import xfh_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic engBusy = 1'b0, engTxPop = 1'b0, engRxPush = 1'b0, engBitErr = 1'b0;
  logic rxTimeoutEvt = 1'b0;
  logic [31:0] txWord;
  logic [31:0] rxWord = '0;
  logic irq, txDmaReq, rxDmaReq;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  xfer_fifo_hub dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .engBusy(engBusy), .engTxPop(engTxPop), .txWord(txWord),
    .engRxPush(engRxPush), .rxWord(rxWord), .engBitErr(engBitErr),
    .rxTimeoutEvt(rxTimeoutEvt), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pushRx(input logic [31:0] d);
    @(negedge clk);
    engRxPush = 1'b1; rxWord = d;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic popTx(output logic [31:0] d);
    @(negedge clk);
    d = txWord; engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  function automatic logic [31:0] expStat(input int txN, input int rxN,
                                          input bit tur, input bit ror, input bit bce);
    logic [31:0] s = '0;
    s[6] = (txN < 32);
    s[11:7] = 5'((32 - txN) % 32);
    s[12] = tur;
    s[14] = (rxN > 0);
    s[19:15] = (rxN > 0) ? 5'(rxN - 1) : 5'd0;
    s[20] = ror;
    s[21] = bce;
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    doRead(REG_CFG, rd);  chk("R1 cfg", rd, 32'h0);
    doRead(REG_IEN, rd);  chk("R1 ien", rd, 32'h0);
    doRead(REG_STAT, rd); chk("R1 status", rd, 32'h40);
    chk("R1 outs", {29'b0, irq, txDmaReq, rxDmaReq}, 32'h0);

    // R2 readback masks
    doWrite(REG_CFG, 32'hFFFF_FFFF); doRead(REG_CFG, rd); chk("R2 cfg", rd, 32'hFFF);
    doWrite(REG_CFG, 32'h0000_0A5C); doRead(REG_CFG, rd); chk("R2 cfg", rd, 32'hA5C);
    doWrite(REG_IEN, 32'hFFFF_FFFF); doRead(REG_IEN, rd); chk("R2 ien", rd, 32'h7E);
    doWrite(REG_IEN, 32'h0000_0015); doRead(REG_IEN, rd); chk("R2 ien", rd, 32'h14);

    // R5 R13 R12 TX level and threshold sweep
    doWrite(REG_IEN, 32'h1 << 3);
    for (int k = 0; k <= 32; k++) begin
      if (k > 0) doWrite(REG_DATA, 32'hA500_0000 + 32'(k - 1));
      doRead(REG_STAT, rd);
      chk("R5 tx status", rd, expStat(k, 0, 0, 0, 0));
      for (int t = 0; t < 32; t++) begin
        doWrite(REG_CFG, 32'(t) | (32'h1 << 10));
        chk("R13 txDmaReq", 32'(txDmaReq), 32'((32 - k) >= t + 1));
        chk("R12 irq tx threshold", 32'(irq), 32'((32 - k) >= t + 1));
        chk("R13 rxDmaReq idle", 32'(rxDmaReq), 32'h0);
      end
    end
    doWrite(REG_DATA, 32'h0000_DEAD);
    doRead(REG_STAT, rd); chk("R3 full drop status", rd, expStat(32, 0, 0, 0, 0));
    for (int i = 0; i < 32; i++) begin
      popTx(rd);
      chk("R3 tx order", rd, 32'hA500_0000 + 32'(i));
    end
    doRead(REG_STAT, rd); chk("R3 tx drained", rd, expStat(0, 0, 0, 0, 0));

    // R8 underrun
    doWrite(REG_IEN, 32'h1 << 5);
    chk("R12 irq tur clear", 32'(irq), 32'h0);
    popTx(rd);
    doRead(REG_STAT, rd); chk("R8 underrun", rd, expStat(0, 0, 1, 0, 0));
    chk("R12 irq tur", 32'(irq), 32'h1);
    doWrite(REG_STAT, 32'h1 << 12);
    doRead(REG_STAT, rd); chk("R10 clear tur", rd, expStat(0, 0, 0, 0, 0));
    chk("R12 irq tur gone", 32'(irq), 32'h0);

    // R6 R13 R12 RX level and threshold sweep
    doWrite(REG_IEN, 32'h1 << 2);
    for (int k = 0; k <= 32; k++) begin
      if (k > 0) pushRx(32'h3C00_0000 + 32'(k - 1));
      doRead(REG_STAT, rd);
      chk("R6 rx status", rd, expStat(0, k, 0, 0, 0));
      for (int t = 0; t < 32; t++) begin
        doWrite(REG_CFG, (32'(t) << 5) | (32'h1 << 11));
        chk("R13 rxDmaReq", 32'(rxDmaReq), 32'(k >= t + 1));
        chk("R12 irq rx threshold", 32'(irq), 32'(k >= t + 1));
        chk("R13 txDmaReq off", 32'(txDmaReq), 32'h0);
      end
    end

    // R7 overrun
    pushRx(32'h0000_0BAD);
    doRead(REG_STAT, rd); chk("R7 overrun", rd, expStat(0, 32, 0, 1, 0));
    for (int i = 0; i < 32; i++) begin
      doRead(REG_DATA, rd);
      chk("R4 rx order", rd, 32'h3C00_0000 + 32'(i));
    end
    doRead(REG_STAT, rd); chk("R6 rx drained", rd, expStat(0, 0, 0, 1, 0));
    doRead(REG_DATA, rd);
    doRead(REG_STAT, rd); chk("R4 empty read", rd, expStat(0, 0, 0, 1, 0));
    pushRx(32'h0000_0077);
    doRead(REG_STAT, rd); chk("R4 single", rd, expStat(0, 1, 0, 1, 0));
    doRead(REG_DATA, rd); chk("R4 single data", rd, 32'h0000_0077);

    // R9 R10 bit-count flag and selective clear
    @(negedge clk) engBitErr = 1'b1;
    @(negedge clk) engBitErr = 1'b0;
    doRead(REG_STAT, rd); chk("R9 bce", rd, expStat(0, 0, 0, 1, 1));
    doWrite(REG_IEN, 32'h1 << 6);
    chk("R12 irq bce", 32'(irq), 32'h1);
    doWrite(REG_STAT, 32'h1 << 20);
    doRead(REG_STAT, rd); chk("R10 selective", rd, expStat(0, 0, 0, 0, 1));
    @(negedge clk);
    engBitErr = 1'b1; busSel = 1'b1; busWrite = 1'b1; busAddr = REG_STAT;
    busWdata = 32'h1 << 21;
    @(negedge clk);
    engBitErr = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    doRead(REG_STAT, rd); chk("R10 set wins", rd, expStat(0, 0, 0, 0, 1));
    doWrite(REG_STAT, 32'hFFFF_FFFF);
    doRead(REG_STAT, rd); chk("R10 clear all", rd, expStat(0, 0, 0, 0, 0));
    chk("R12 irq bce gone", 32'(irq), 32'h0);
    doWrite(REG_IEN, 32'h1 << 4);
    chk("R12 irq ror clear", 32'(irq), 32'h0);

    // R12 timeout term
    doWrite(REG_IEN, 32'h1 << 1);
    @(negedge clk) rxTimeoutEvt = 1'b1;
    #1 chk("R12 irq timeout", 32'(irq), 32'h1);
    doWrite(REG_IEN, 32'h0);
    #1 chk("R12 irq timeout masked", 32'(irq), 32'h0);
    @(negedge clk) rxTimeoutEvt = 1'b0;

    // R11 busy
    @(negedge clk) engBusy = 1'b1;
    doRead(REG_STAT, rd); chk("R11 busy", rd, 32'h41);
    @(negedge clk) engBusy = 1'b0;
    doRead(REG_STAT, rd); chk("R11 idle", rd, 32'h40);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule